// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Path

This block is a purely combinational unsigned adder. It returns the sum of two words and a carry-in, together with the carry out of the top bit. The word is cut into slices that get wider towards the most significant end. The lowest slice is an ordinary ripple adder fed by the external carry-in. Every higher slice works out its result once, assuming its incoming carry is zero. An add-one converter then turns that result into the answer for an incoming carry of one. A two-way selector, steered by the carry coming out of the slice below, picks the answer that applies.

Each slice's sum is ready before its incoming carry arrives, and the converter is cheaper than a second ripple adder. The long carry path is therefore only the chain of selectors, one per slice. The block drops into any datapath that needs a fast adder of moderate width. Its single parameter sets the word width. The slice layout is derived from that parameter.

Top module: `sqrt_csla`

## Requirements
- R1: For every input combination, the concatenation {cout, sum} equals the unsigned value a + b + cin, computed WIDTH+1 bits wide.
- R2: The word is split from bit 0 upwards into slices of 2, 2, 3, 4 and 5 bits, so the slices start at bits 0, 2, 4, 7 and 11 when WIDTH is 16. For larger widths each further slice is one bit wider than the one before, and the last slice keeps only the bits that remain. With WIDTH 32 the slices are 2, 2, 3, 4, 5, 6, 7 and 3 bits, starting at 0, 2, 4, 7, 11, 16, 22 and 29.
- R3: The lowest slice is a ripple adder whose carry-in is cin. Its sum bits and its carry out equal the low two bits of a plus those of b plus cin.
- R4: In each upper slice, the add-one converter's (n+1)-bit output equals the carry-in-zero result, taken as its n sum bits plus its carry out, plus one. The converter's own overflow flag never rises inside the adder.
- R5: Each upper slice delivers the converter result when the carry out of the slice below is 1, and the carry-in-zero result when it is 0.
- R6: cout is the selected carry of the top slice. It is 1 exactly when a + b + cin is at least 2^WIDTH.
- R7: A carry generated at bit 0 runs through every slice boundary. For example, a all ones, b zero and cin 1 give sum 0 and cout 1.
- R8: The add-one converter, taken alone with input p, gives output (p + 1) modulo 2^M and flag 1 exactly when p is all ones. Output bit 0 is the inverse of p bit 0. Output bit i is p bit i XOR the AND of all lower p bits. A 4-bit input of 1111 gives 0000 with the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder twice: once at the default WIDTH of 16, which gives five slices, and once at 32, which adds three more slices and a clipped top slice of 3 bits. The 16-bit copy takes carries that stop exactly at each slice start (2, 4, 7, 11), the all-ones cases and random vectors. The 32-bit copy reaches the clipped last slice and the longer selector chain, including carries ending at bits 16, 22 and 29. A 4-bit converter is also instantiated on its own and driven through all sixteen inputs, so its wrap case can be seen directly.

// File: rtl/sqrt_csla_pkg.sv
package sqrt_csla_pkg;

    // Width of the lowest slice; every later slice grows by one bit.
    localparam int BASE_SLICE_W = 2;

    function automatic int nominal_w(input int g);
        return (g == 0) ? BASE_SLICE_W : g + 1;
    endfunction

    // Start bit of slice g for a word of width w.
    function automatic int grp_lo(input int w, input int g);
        int lo;
        lo = 0;
        for (int i = 0; i < g; i++) begin
            lo += nominal_w(i);
        end
        return (lo > w) ? w : lo;
    endfunction

    // Width of slice g; the top slice is clipped to the bits left.
    function automatic int grp_w(input int w, input int g);
        int room;
        room = w - grp_lo(w, g);
        return (nominal_w(g) < room) ? nominal_w(g) : room;
    endfunction

    function automatic int num_groups(input int w);
        int n;
        int lo;
        n  = 0;
        lo = 0;
        while (lo < w) begin
            lo += nominal_w(n);
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/csla_ripple.sv
module csla_ripple #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic p;
        assign p      = a[i] ^ b[i];
        assign s[i]   = p ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
    end

    assign co = c[N];
endmodule

// File: rtl/csla_excess_one.sv
module csla_excess_one #(
    parameter int M = 4
) (
    input  logic [M-1:0] p,
    output logic [M-1:0] q,
    output logic         cy
);
    // run[i] is the AND of p[i-1:0]; it decides whether bit i flips.
    logic [M:0] run;

    assign run[0] = 1'b1;

    for (genvar i = 0; i < M; i++) begin : g_bit
        assign q[i]     = p[i] ^ run[i];
        assign run[i+1] = run[i] & p[i];
    end

    assign cy = run[M];
endmodule

// File: rtl/csla_group.sv
module csla_group #(
    parameter int N = 3
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel,
    output logic [N-1:0] s,
    output logic         co,
    output logic [N-1:0] z_s,
    output logic         z_co,
    output logic [N-1:0] x_s,
    output logic         x_co,
    output logic         x_cy
);
    csla_ripple #(.N(N)) u_rca0 (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (z_s),
        .co (z_co)
    );

    csla_excess_one #(.M(N + 1)) u_inc (
        .p  ({z_co, z_s}),
        .q  ({x_co, x_s}),
        .cy (x_cy)
    );

    assign s  = sel ? x_s  : z_s;
    assign co = sel ? x_co : z_co;
endmodule

// File: rtl/sqrt_csla.sv
module sqrt_csla
    import sqrt_csla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NGRP = num_groups(WIDTH);

    logic [NGRP:0]    gcar;
    logic [WIDTH-1:0] rc_sum;
    logic [WIDTH-1:0] inc_sum;
    logic [NGRP-1:0]  rc_co;
    logic [NGRP-1:0]  inc_co;
    logic [NGRP-1:0]  inc_ovf;

    assign gcar[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        localparam int LO = grp_lo(WIDTH, g);
        localparam int GW = grp_w(WIDTH, g);

        if (g == 0) begin : g_base
            csla_ripple #(.N(GW)) u_rca (
                .a  (a[LO +: GW]),
                .b  (b[LO +: GW]),
                .ci (gcar[0]),
                .s  (sum[LO +: GW]),
                .co (gcar[1])
            );
            assign rc_sum[LO +: GW]  = sum[LO +: GW];
            assign inc_sum[LO +: GW] = '0;
            assign rc_co[0]          = gcar[1];
            assign inc_co[0]         = 1'b0;
            assign inc_ovf[0]        = 1'b0;
        end else begin : g_sel
            csla_group #(.N(GW)) u_grp (
                .a    (a[LO +: GW]),
                .b    (b[LO +: GW]),
                .sel  (gcar[g]),
                .s    (sum[LO +: GW]),
                .co   (gcar[g+1]),
                .z_s  (rc_sum[LO +: GW]),
                .z_co (rc_co[g]),
                .x_s  (inc_sum[LO +: GW]),
                .x_co (inc_co[g]),
                .x_cy (inc_ovf[g])
            );
        end
    end

    assign cout = gcar[NGRP];
endmodule

// File: rtl/sqrt_csla_chk.sv
module sqrt_csla_chk
    import sqrt_csla_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int NG = num_groups(WIDTH)
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NG:0]      gcar,
    input logic [WIDTH-1:0] rc_sum,
    input logic [WIDTH-1:0] inc_sum,
    input logic [NG-1:0]    rc_co,
    input logic [NG-1:0]    inc_co,
    input logic [NG-1:0]    inc_ovf
);
    longint unsigned full_ref;
    longint unsigned msk;
    longint unsigned zr;
    longint unsigned xr;
    longint unsigned sg;
    int lo;
    int gw;

    always_comb begin
        full_ref = 64'(a) + 64'(b) + 64'(cin);
        p_sum_exact_r1: assert ({cout, sum} == (WIDTH+1)'(full_ref))
            else $error("R1 adder mismatch");

        gw  = grp_w(WIDTH, 0);
        msk = (64'd1 << gw) - 64'd1;
        zr  = (64'(a) & msk) + (64'(b) & msk) + 64'(cin);
        sg  = (64'(sum) & msk) | (64'(gcar[1]) << gw);
        p_low_ripple_r3: assert (sg == zr)
            else $error("R3 low slice mismatch");

        for (int g = 1; g < NG; g++) begin
            lo  = grp_lo(WIDTH, g);
            gw  = grp_w(WIDTH, g);
            msk = (64'd1 << gw) - 64'd1;
            zr  = ((64'(rc_sum)  >> lo) & msk) | (64'(rc_co[g])  << gw);
            xr  = ((64'(inc_sum) >> lo) & msk) | (64'(inc_co[g]) << gw);
            sg  = ((64'(sum)     >> lo) & msk) | (64'(gcar[g+1]) << gw);
            p_plus_one_r4: assert (xr == zr + 64'd1)
                else $error("R4 converter not one above zero-carry result");
            p_no_wrap_r4: assert (!inc_ovf[g])
                else $error("R4 converter flag raised");
            p_select_r5: assert (sg == (gcar[g] ? xr : zr))
                else $error("R5 wrong selection");
        end
    end
endmodule

bind sqrt_csla sqrt_csla_chk #(.WIDTH(WIDTH)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .gcar    (gcar),
    .rc_sum  (rc_sum),
    .inc_sum (inc_sum),
    .rc_co   (rc_co),
    .inc_co  (inc_co),
    .inc_ovf (inc_ovf)
);

// File: tb/sim_sqrt_csla.sv
module sim_sqrt_csla;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [3:0]  cv_p, cv_q;
    logic        cv_cy;

    sqrt_csla #(.WIDTH(16)) u0 (
        .a(a16), .b(b16), .cin(c16), .sum(s16), .cout(co16)
    );

    sqrt_csla #(.WIDTH(32)) u1 (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32)
    );

    csla_excess_one #(.M(4)) u_cv (
        .p(cv_p), .q(cv_q), .cy(cv_cy)
    );

    task automatic add16(input string req, input logic [15:0] x,
                         input logic [15:0] y, input logic ci);
        logic [16:0] exp;
        @(posedge clk);
        a16 = x; b16 = y; c16 = ci;
        exp = {1'b0, x} + {1'b0, y} + 17'(ci);
        @(negedge clk);
        checks++;
        if ({co16, s16} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, x, y, ci, {co16, s16}, exp);
        end
    endtask

    task automatic add32(input string req, input logic [31:0] x,
                         input logic [31:0] y, input logic ci);
        logic [32:0] exp;
        @(posedge clk);
        a32 = x; b32 = y; c32 = ci;
        exp = {1'b0, x} + {1'b0, y} + 33'(ci);
        @(negedge clk);
        checks++;
        if ({co32, s32} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, x, y, ci, {co32, s32}, exp);
        end
    endtask

    // Zero operands: output must be all zero.
    task automatic t_idle();
        add16("R1 zero", 16'h0000, 16'h0000, 1'b0);
        add32("R1 zero", 32'h0, 32'h0, 1'b0);
    endtask

    // All-ones and full-chain cases.
    task automatic t_corners();
        add16("R7 full chain", 16'hFFFF, 16'h0000, 1'b1);
        add16("R6 max", 16'hFFFF, 16'hFFFF, 1'b1);
        add16("R6 no carry", 16'hFFFF, 16'h0000, 1'b0);
        add16("R6 top carry", 16'h8000, 16'h8000, 1'b0);
        add16("R3 low slice", 16'h0003, 16'h0001, 1'b1);
        add16("R3 cin only", 16'h0000, 16'h0000, 1'b1);
        add32("R7 full chain", 32'hFFFF_FFFF, 32'h0, 1'b1);
        add32("R6 max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    // Carries ending exactly at each slice start (R2 layout).
    task automatic t_boundaries();
        int b16s[4] = '{2, 4, 7, 11};
        int b32s[7] = '{2, 4, 7, 11, 16, 22, 29};
        foreach (b16s[i]) begin
            add16("R2 R5 boundary cin", 16'((32'd1 << b16s[i]) - 1), 16'h0, 1'b1);
            add16("R2 R5 boundary gen", 16'(32'd1 << (b16s[i] - 1)),
                  16'(32'd1 << (b16s[i] - 1)), 1'b0);
            add16("R2 R5 stop below", 16'((32'd1 << b16s[i]) - 2), 16'h0, 1'b1);
        end
        foreach (b32s[i]) begin
            add32("R2 R5 boundary cin", 32'((64'd1 << b32s[i]) - 1), 32'h0, 1'b1);
            add32("R2 R5 boundary gen", 32'(64'd1 << (b32s[i] - 1)),
                  32'(64'd1 << (b32s[i] - 1)), 1'b0);
        end
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            add16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
            add32("R1 random", $urandom, $urandom, 1'($urandom));
        end
    endtask

    task automatic t_converter();
        for (int v = 0; v < 16; v++) begin
            logic [3:0] eq;
            logic       ecy;
            @(posedge clk);
            cv_p = 4'(v);
            eq  = 4'(v + 1);
            ecy = (v == 15);
            @(negedge clk);
            checks++;
            if (cv_q !== eq || cv_cy !== ecy) begin
                errors++;
                $display("FAIL R8 p=%h actual=%b/%h expected=%b/%h",
                         4'(v), cv_cy, cv_q, ecy, eq);
            end
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        cv_p = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_corners();
        t_boundaries();
        t_random();
        t_converter();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule